// File: doc/BRIEF.md
# Cross-Clock RAM Completion Bridge

This block joins a fast RAM clock domain to a slower general logic clock domain. The two clocks have no fixed phase relationship. A RAM controller in the fast domain signals each finished access with a strobe that lasts one fast cycle. A strobe that short can rise and fall entirely between two slow-clock edges, so the slow domain never samples it. Instead, every strobe writes one entry into a small dual-clock FIFO. A read completion stores the 16-bit word that was read. A write completion stores an acknowledgement tag with no data.

On the slow side, a three-state pop engine drains the FIFO. For each entry it produces one done pulse in the slow domain, together with the entry's kind and data. The requesting link controller waits for this pulse.

The bridge also carries requests the other way, from the slow side to the fast side. It does this with a toggle crossing, and it refuses a new request until the done pulse for the current one has appeared.

Top module: `ram_resp_bridge`

## Requirements
- R1: After reset, `s_done`, `s_busy`, `f_req` and `f_overflow` are 0, and the FIFO is empty, so no done pulse appears until a completion strobe arrives.
- R2: Each `f_cmpl` strobe with `f_cmpl_wr`=0 gives exactly one `s_done` pulse. That pulse has `s_done_wr`=0 and `s_done_data` equal to the `f_cmpl_data` captured with the strobe.
- R3: Each `f_cmpl` strobe with `f_cmpl_wr`=1 gives exactly one `s_done` pulse with `s_done_wr`=1 and `s_done_data`=0, whatever `f_cmpl_data` held.
- R4: Done pulses come out in the same order as the strobes that were accepted, including runs that mix reads and writes.
- R5: `s_done` is high for exactly one slow cycle. `s_done_wr` and `s_done_data` do not change from that pulse until the next pulse.
- R6: The FIFO holds 4 entries. A strobe that arrives while the FIFO is full is dropped, and the entries already stored are delivered unharmed.
- R7: A dropped strobe sets `f_overflow`. It stays 1 until reset, and reset clears it to 0.
- R8: When `s_req` is 1 while `s_busy` is 0, `s_busy` rises on the next slow edge. Exactly one one-cycle `f_req` pulse then appears, carrying the `s_req_wr` and `s_req_word` values that were presented with the request.
- R9: A request presented while `s_busy` is 1 is ignored. It produces no `f_req` pulse, and it does not change the kind or word of the request already pending.
- R10: `s_busy` falls on the slow edge right after a `s_done` pulse, so that a new request can be accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_f | input | 1 | Fast RAM-domain clock |
| rst_f | input | 1 | Synchronous active-high reset, fast domain |
| clk_s | input | 1 | Slow logic-domain clock |
| rst_s | input | 1 | Synchronous active-high reset, slow domain |
| s_req | input | 1 | Request strobe from the slow-side requester |
| s_req_wr | input | 1 | Request kind: 1 = RAM write, 0 = RAM read |
| s_req_word | input | 16 | Request payload (address or write word) |
| s_busy | output | 1 | A request is outstanding and no done pulse has arrived yet |
| s_done | output | 1 | One-slow-cycle completion pulse |
| s_done_wr | output | 1 | Kind of the completion popped: 1 = write acknowledgement |
| s_done_data | output | 16 | Read word of the completion, or 0 for a write acknowledgement |
| f_req | output | 1 | One-fast-cycle request pulse to the RAM controller |
| f_req_wr | output | 1 | Kind of the request delivered |
| f_req_word | output | 16 | Payload of the request delivered |
| f_cmpl | input | 1 | One-fast-cycle completion strobe from the RAM controller |
| f_cmpl_wr | input | 1 | Completion kind: 1 = write, 0 = read |
| f_cmpl_data | input | 16 | Read word that comes with the completion strobe |
| f_overflow | output | 1 | Sticky flag: a completion was dropped because the FIFO was full |

## Verification
Request and response round trips run with random kinds, random words and a random RAM-side latency, so completions arrive at many phases of the slow clock. This separates a correct crossing from one that loses or duplicates strobes. Some of these trips also present a second request while the bridge is busy. That shows whether the busy lock holds or a stray fast-side pulse leaks through. Directed bursts of back-to-back completion strobes do two jobs. A short mixed read/write run checks ordering and the zeroing of write acknowledgements. A long run overruns the four entries, which shows that drops fall only on strobes that found the FIFO full, that the overflow flag stays set, and that reset clears it.

// File: rtl/rrb_pkg.sv
`timescale 1ns/1ps
package rrb_pkg;
  localparam int unsigned RRB_WORD_W = 16;
  localparam int unsigned RRB_DEPTH  = 4;

  typedef enum logic [1:0] {
    RD_IDLE = 2'd0,
    RD_POP  = 2'd1,
    RD_DONE = 2'd2
  } rd_state_t;
endpackage

// File: rtl/rrb_sync2.sv
`timescale 1ns/1ps
module rrb_sync2 #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/rrb_wr_side.sv
`timescale 1ns/1ps
module rrb_wr_side #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 4,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned PW    = AW + 1,
  localparam int unsigned EW    = DATA_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic              push_wr,
  input  logic [DATA_W-1:0] push_data,
  input  logic [PW-1:0]     rd_gray_s,
  output logic              wr_en,
  output logic [AW-1:0]     wr_addr,
  output logic [EW-1:0]     wr_entry,
  output logic [PW-1:0]     wr_gray,
  output logic              overflow
);
  logic [PW-1:0] wr_bin;
  logic [PW-1:0] wr_bin_nxt;
  logic          full;

  // full: write pointer has lapped the synchronized read pointer by DEPTH
  assign full       = (wr_gray == (rd_gray_s ^ {2'b11, {(PW-2){1'b0}}}));
  assign wr_en      = push && !full;
  assign wr_addr    = wr_bin[AW-1:0];
  assign wr_entry   = {push_wr, (push_wr ? {DATA_W{1'b0}} : push_data)};
  assign wr_bin_nxt = wr_bin + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_bin   <= '0;
      wr_gray  <= '0;
      overflow <= 1'b0;
    end else begin
      if (wr_en) begin
        wr_bin  <= wr_bin_nxt;
        wr_gray <= wr_bin_nxt ^ (wr_bin_nxt >> 1);
      end
      if (push && full) overflow <= 1'b1;
    end
  end

  a_r6_full_drops: assert property (@(posedge clk) disable iff (rst)
    (push && full) |=> (wr_bin == $past(wr_bin)));
  a_r2_ptr_advance: assert property (@(posedge clk) disable iff (rst)
    (push && !full) |=> (wr_bin == $past(wr_bin) + 1'b1));
  a_r7_sticky_overflow: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);
endmodule

// File: rtl/rrb_rd_side.sv
`timescale 1ns/1ps
module rrb_rd_side
  import rrb_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 4,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned PW    = AW + 1,
  localparam int unsigned EW    = DATA_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PW-1:0]     wr_gray_s,
  input  logic [EW-1:0]     rd_entry,
  output logic [AW-1:0]     rd_addr,
  output logic [PW-1:0]     rd_gray,
  output logic              done,
  output logic              done_wr,
  output logic [DATA_W-1:0] done_data
);
  rd_state_t     st;
  logic [PW-1:0] rd_bin;
  logic [PW-1:0] rd_bin_nxt;
  logic          empty;

  assign empty      = (rd_gray == wr_gray_s);
  assign rd_addr    = rd_bin[AW-1:0];
  assign rd_bin_nxt = rd_bin + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= RD_IDLE;
      rd_bin    <= '0;
      rd_gray   <= '0;
      done      <= 1'b0;
      done_wr   <= 1'b0;
      done_data <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        RD_IDLE: if (!empty) st <= RD_POP;
        RD_POP: begin
          done      <= 1'b1;
          done_wr   <= rd_entry[DATA_W];
          done_data <= rd_entry[DATA_W-1:0];
          rd_bin    <= rd_bin_nxt;
          rd_gray   <= rd_bin_nxt ^ (rd_bin_nxt >> 1);
          st        <= RD_DONE;
        end
        RD_DONE: st <= RD_IDLE;
        default: st <= RD_IDLE;
      endcase
    end
  end

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r5_data_held: assert property (@(posedge clk) disable iff (rst)
    done |=> ($stable(done_data) && $stable(done_wr)));
  a_r1_no_pop_when_empty: assert property (@(posedge clk) disable iff (rst)
    (st == RD_IDLE && empty) |=> !done);
endmodule

// File: rtl/rrb_req_xfer.sv
`timescale 1ns/1ps
module rrb_req_xfer #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_s,
  input  logic              rst_s,
  input  logic              s_req,
  input  logic              s_req_wr,
  input  logic [DATA_W-1:0] s_req_word,
  input  logic              s_done,
  output logic              s_busy,
  input  logic              clk_f,
  input  logic              rst_f,
  output logic              f_req,
  output logic              f_req_wr,
  output logic [DATA_W-1:0] f_req_word
);
  logic              tog_s;
  logic              hold_wr;
  logic [DATA_W-1:0] hold_word;
  logic              tog_f;
  logic              tog_f_prev;
  logic              accept;

  assign accept = s_req && !s_busy;

  always_ff @(posedge clk_s) begin
    if (rst_s) begin
      tog_s     <= 1'b0;
      s_busy    <= 1'b0;
      hold_wr   <= 1'b0;
      hold_word <= '0;
    end else begin
      if (accept) begin
        tog_s     <= ~tog_s;
        s_busy    <= 1'b1;
        hold_wr   <= s_req_wr;
        hold_word <= s_req_word;
      end else if (s_done) begin
        s_busy <= 1'b0;
      end
    end
  end

  rrb_sync2 #(.W(1)) u_tog_sync (
    .clk (clk_f),
    .rst (rst_f),
    .d   (tog_s),
    .q   (tog_f)
  );

  // hold_* settled at least two fast edges before the toggle is seen
  always_ff @(posedge clk_f) begin
    if (rst_f) begin
      tog_f_prev <= 1'b0;
      f_req      <= 1'b0;
      f_req_wr   <= 1'b0;
      f_req_word <= '0;
    end else begin
      tog_f_prev <= tog_f;
      f_req      <= tog_f ^ tog_f_prev;
      if (tog_f ^ tog_f_prev) begin
        f_req_wr   <= hold_wr;
        f_req_word <= hold_word;
      end
    end
  end

  a_r8_busy_on_accept: assert property (@(posedge clk_s) disable iff (rst_s)
    accept |=> s_busy);
  a_r9_locked_while_busy: assert property (@(posedge clk_s) disable iff (rst_s)
    (s_busy && !s_done) |=> (s_busy && $stable(tog_s) && $stable(hold_word)));
  a_r8_req_one_cycle: assert property (@(posedge clk_f) disable iff (rst_f)
    f_req |=> !f_req);
endmodule

// File: rtl/ram_resp_bridge.sv
`timescale 1ns/1ps
module ram_resp_bridge #(
  parameter int unsigned DATA_W = rrb_pkg::RRB_WORD_W,
  parameter int unsigned DEPTH  = rrb_pkg::RRB_DEPTH,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned PW    = AW + 1,
  localparam int unsigned EW    = DATA_W + 1
) (
  input  logic              clk_f,
  input  logic              rst_f,
  input  logic              clk_s,
  input  logic              rst_s,
  input  logic              s_req,
  input  logic              s_req_wr,
  input  logic [DATA_W-1:0] s_req_word,
  output logic              s_busy,
  output logic              s_done,
  output logic              s_done_wr,
  output logic [DATA_W-1:0] s_done_data,
  output logic              f_req,
  output logic              f_req_wr,
  output logic [DATA_W-1:0] f_req_word,
  input  logic              f_cmpl,
  input  logic              f_cmpl_wr,
  input  logic [DATA_W-1:0] f_cmpl_data,
  output logic              f_overflow
);
  logic [EW-1:0] mem [DEPTH];
  logic [EW-1:0] rd_q;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [EW-1:0] wr_entry;
  logic [AW-1:0] rd_addr;
  logic [PW-1:0] wr_gray, wr_gray_s;
  logic [PW-1:0] rd_gray, rd_gray_f;

  rrb_wr_side #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_wr (
    .clk       (clk_f),
    .rst       (rst_f),
    .push      (f_cmpl),
    .push_wr   (f_cmpl_wr),
    .push_data (f_cmpl_data),
    .rd_gray_s (rd_gray_f),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_entry  (wr_entry),
    .wr_gray   (wr_gray),
    .overflow  (f_overflow)
  );

  // dual-clock storage, written fast, read slow with a registered port
  always_ff @(posedge clk_f) begin
    if (wr_en) mem[wr_addr] <= wr_entry;
  end

  always_ff @(posedge clk_s) begin
    rd_q <= mem[rd_addr];
  end

  rrb_sync2 #(.W(PW)) u_wptr_sync (
    .clk (clk_s),
    .rst (rst_s),
    .d   (wr_gray),
    .q   (wr_gray_s)
  );

  rrb_sync2 #(.W(PW)) u_rptr_sync (
    .clk (clk_f),
    .rst (rst_f),
    .d   (rd_gray),
    .q   (rd_gray_f)
  );

  rrb_rd_side #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rd (
    .clk       (clk_s),
    .rst       (rst_s),
    .wr_gray_s (wr_gray_s),
    .rd_entry  (rd_q),
    .rd_addr   (rd_addr),
    .rd_gray   (rd_gray),
    .done      (s_done),
    .done_wr   (s_done_wr),
    .done_data (s_done_data)
  );

  rrb_req_xfer #(.DATA_W(DATA_W)) u_req (
    .clk_s      (clk_s),
    .rst_s      (rst_s),
    .s_req      (s_req),
    .s_req_wr   (s_req_wr),
    .s_req_word (s_req_word),
    .s_done     (s_done),
    .s_busy     (s_busy),
    .clk_f      (clk_f),
    .rst_f      (rst_f),
    .f_req      (f_req),
    .f_req_wr   (f_req_wr),
    .f_req_word (f_req_word)
  );

  a_r10_release_busy: assert property (@(posedge clk_s) disable iff (rst_s)
    (s_done && !s_req) |=> !s_busy);
endmodule

// File: tb/ram_resp_bridge_tb.sv
`timescale 1ns/1ps
module ram_resp_bridge_tb;
  logic clk_f = 1'b0, clk_s = 1'b0;
  logic rst_f = 1'b1, rst_s = 1'b1;
  logic s_req = 1'b0, s_req_wr = 1'b0;
  logic [15:0] s_req_word = '0;
  logic s_busy, s_done, s_done_wr, f_req, f_req_wr, f_overflow;
  logic [15:0] s_done_data, f_req_word;
  logic f_cmpl = 1'b0, f_cmpl_wr = 1'b0;
  logic [15:0] f_cmpl_data = '0;

  always #2.5 clk_f = ~clk_f;   // 200 MHz
  always #5.5 clk_s = ~clk_s;   // unrelated slower clock

  ram_resp_bridge u_dut (
    .clk_f(clk_f), .rst_f(rst_f), .clk_s(clk_s), .rst_s(rst_s),
    .s_req(s_req), .s_req_wr(s_req_wr), .s_req_word(s_req_word),
    .s_busy(s_busy), .s_done(s_done), .s_done_wr(s_done_wr),
    .s_done_data(s_done_data), .f_req(f_req), .f_req_wr(f_req_wr),
    .f_req_word(f_req_word), .f_cmpl(f_cmpl), .f_cmpl_wr(f_cmpl_wr),
    .f_cmpl_data(f_cmpl_data), .f_overflow(f_overflow)
  );

  int vectors = 0, miscompares = 0;
  logic [15:0] got_data[$];
  bit          got_wr[$];
  bit          prev_done = 1'b0;
  int          freq_cnt = 0;
  bit          exp_req_wr = 1'b0;
  logic [15:0] exp_req_word = '0;
  int          burst_n = 0, burst_idx = 0;
  bit          burst_mix = 1'b0;
  logic [15:0] burst_base = '0;

  function automatic logic [15:0] resp_of(input logic [15:0] w);
    return w ^ 16'h5A3C;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  // slow-side monitor: collect done pulses, check pulse width
  always @(negedge clk_s) begin
    if (rst_s) prev_done = 1'b0;
    else begin
      if (s_done) begin
        if (prev_done) chk(1'b0, "R5 pulse width", 32'd2, 32'd1);
        got_data.push_back(s_done_data);
        got_wr.push_back(s_done_wr);
      end
      prev_done = s_done;
    end
  end

  // fast-side model of the RAM controller
  initial begin
    int pend;
    bit pend_wr;
    logic [15:0] pend_word;
    pend = 0; pend_wr = 1'b0; pend_word = '0;
    forever begin
      @(negedge clk_f);
      f_cmpl = 1'b0;
      if (rst_f) pend = 0;
      else begin
        if (f_req) freq_cnt++;
        if (burst_n > 0) begin
          f_cmpl      = 1'b1;
          f_cmpl_wr   = burst_mix & burst_idx[0];
          f_cmpl_data = burst_base + 16'(burst_idx);
          burst_idx++;
          burst_n--;
        end else if (pend == 0 && f_req) begin
          chk(f_req_wr == exp_req_wr, "R8 f_req_wr", 32'(f_req_wr), 32'(exp_req_wr));
          chk(f_req_word == exp_req_word, "R8 f_req_word", 32'(f_req_word), 32'(exp_req_word));
          pend_wr = f_req_wr; pend_word = f_req_word;
          pend = 1 + int'($urandom % 4);
        end else if (pend > 0) begin
          pend--;
          if (pend == 0) begin
            f_cmpl      = 1'b1;
            f_cmpl_wr   = pend_wr;
            f_cmpl_data = pend_wr ? 16'hDEAD : resp_of(pend_word);
          end
        end
      end
    end
  end

  task automatic do_reset();
    @(negedge clk_s);
    rst_f = 1'b1; rst_s = 1'b1;
    repeat (4) @(negedge clk_s);
    rst_f = 1'b0; rst_s = 1'b0;
    @(negedge clk_s);
    got_data.delete(); got_wr.delete();
  endtask

  task automatic wait_slow(input int n);
    repeat (n) @(negedge clk_s);
  endtask

  task automatic txn(input bit wr, input logic [15:0] w, input bit dup);
    int n0, k;
    logic [15:0] d;
    bit dw;
    n0 = freq_cnt;
    @(negedge clk_s);
    exp_req_wr = wr; exp_req_word = w;
    s_req = 1'b1; s_req_wr = wr; s_req_word = w;
    @(negedge clk_s);
    s_req = 1'b0;
    chk(s_busy == 1'b1, "R8 busy set", 32'(s_busy), 32'd1);
    if (dup) begin
      s_req = 1'b1; s_req_wr = ~wr; s_req_word = ~w;
      @(negedge clk_s);
      s_req = 1'b0;
    end
    k = 0;
    while (got_data.size() == 0 && k < 200) begin @(negedge clk_s); k++; end
    chk(got_data.size() == 1, wr ? "R3 done count" : "R2 done count", 32'(got_data.size()), 32'd1);
    if (got_data.size() > 0) begin
      d = got_data.pop_front(); dw = got_wr.pop_front();
      chk(dw == wr, wr ? "R3 kind" : "R2 kind", 32'(dw), 32'(wr));
      chk(d == (wr ? 16'h0 : resp_of(w)), wr ? "R3 data" : "R2 data", 32'(d), 32'(wr ? 16'h0 : resp_of(w)));
    end
    @(negedge clk_s);
    chk(s_busy == 1'b0, "R10 busy released", 32'(s_busy), 32'd0);
    wait_slow(6);
    chk(got_data.size() == 0, "R2 no extra done", 32'(got_data.size()), 32'd0);
    chk(freq_cnt - n0 == 1, dup ? "R9 ignored request" : "R8 one f_req", 32'(freq_cnt - n0), 32'd1);
  endtask

  initial begin
    void'($urandom(32'h00C0FFEE));
    #500000;
    chk(1'b0, "watchdog", 32'd1, 32'd0);
    finish_run();
  end

  initial begin
    int cnt;
    logic [15:0] prev, v;
    do_reset();
    // R1: idle state after reset
    chk(s_done == 1'b0, "R1 done", 32'(s_done), 32'd0);
    chk(s_busy == 1'b0, "R1 busy", 32'(s_busy), 32'd0);
    chk(f_req == 1'b0, "R1 f_req", 32'(f_req), 32'd0);
    chk(f_overflow == 1'b0, "R1 overflow", 32'(f_overflow), 32'd0);
    wait_slow(20);
    chk(got_data.size() == 0, "R1 empty", 32'(got_data.size()), 32'd0);

    // directed round trips
    txn(1'b0, 16'h0000, 1'b0);
    txn(1'b1, 16'hFFFF, 1'b0);
    txn(1'b0, 16'hFFFF, 1'b1);

    // R4: short mixed burst, fits in the FIFO
    @(negedge clk_f);
    burst_base = 16'h0200; burst_idx = 0; burst_mix = 1'b1; burst_n = 3;
    wait_slow(40);
    chk(got_data.size() == 3, "R4 mixed count", 32'(got_data.size()), 32'd3);
    for (int i = 0; i < 3; i++) begin
      if (got_data.size() > 0) begin
        v = got_data.pop_front();
        cnt = int'(got_wr.pop_front());
        chk(cnt == (i % 2), "R4 mixed kind", 32'(cnt), 32'(i % 2));
        chk(v == ((i % 2) ? 16'h0 : 16'h0200 + 16'(i)), "R4 mixed order", 32'(v),
            32'((i % 2) ? 16'h0 : 16'h0200 + 16'(i)));
      end
    end
    chk(f_overflow == 1'b0, "R7 no overflow yet", 32'(f_overflow), 32'd0);

    // random round trips
    for (int i = 0; i < 40; i++)
      txn(1'($urandom), 16'($urandom), ($urandom % 4) == 0);

    // R6: overrun with 12 back-to-back read strobes
    @(negedge clk_f);
    burst_base = 16'h1000; burst_idx = 0; burst_mix = 1'b0; burst_n = 12;
    wait_slow(100);
    cnt = got_data.size();
    chk(cnt >= 4 && cnt < 12, "R6 drops when full", 32'(cnt), 32'd4);
    chk(f_overflow == 1'b1, "R7 overflow set", 32'(f_overflow), 32'd1);
    prev = 16'h0FFF;
    for (int i = 0; i < cnt; i++) begin
      v = got_data.pop_front();
      void'(got_wr.pop_front());
      if (i < 4) chk(v == 16'h1000 + 16'(i), "R6 stored entries intact", 32'(v), 32'(16'h1000 + 16'(i)));
      chk(v > prev, "R4 ascending after drops", 32'(v), 32'(prev));
      prev = v;
    end

    // R7: sticky through later traffic, cleared by reset
    txn(1'b0, 16'h1234, 1'b0);
    chk(f_overflow == 1'b1, "R7 sticky", 32'(f_overflow), 32'd1);
    do_reset();
    chk(f_overflow == 1'b0, "R7 reset clears", 32'(f_overflow), 32'd0);
    wait_slow(10);
    chk(got_data.size() == 0, "R1 empty after reset", 32'(got_data.size()), 32'd0);
    txn(1'b1, 16'h8001, 1'b1);

    finish_run();
  end
endmodule